// File: doc/BRIEF.md
# Switch-Driven Serial Register Loader

This block takes the place of a host controller for a line-interface chip. That chip keeps its settings in seven 4-bit registers behind a three-wire serial port. Banks of static switches set the register contents. When a write is triggered, the loader sends the whole writable register image over the port: a chip-select, a serial clock and a data line towards the chip. A write is triggered by a press of a momentary button, or by any edge of an external hook-command level. Both trigger sources stay active at the same time.

In manual writes, the top bit of the control switch bank is the off-hook bit itself. In automatic writes, the same switch gives the polarity of the hook command that means off-hook. When the read-mode input is high, the loader polls the status register and the echo bit between writes. It reads them over the chip's data-out line and drives LEDs from the results.

Top module: `swcfg_serial_ctl`

## Requirements
- R1: Each transaction is one 8-bit frame with `ser_cs_n` low and `ser_clk` idling low. Bits go out MSB first: a direction flag (1 = read, 0 = write), a 3-bit register address, then 4 data bits. `ser_din` changes only while `ser_clk` is low, and the chip samples it on the rising edge.
- R2: A write sequence sends five write frames, in the address order 0, 1, 2, 3, 5. Address 0 carries `{off-hook bit, sw_ctrl[2:0]}`. Address 1 carries `sw_lsp_a`. Address 2 carries `sw_lsp_b` with bit 1 forced to 0. Address 3 carries `sw_thr`. Address 5 carries `{0, sw_div}`.
- R3: A write started by the button uses `sw_ctrl[3]` as the off-hook bit (address 0, bit 3).
- R4: Every debounced rising or falling edge of `hook_in` starts a full write sequence.
- R5: A write started by `hook_in` uses the debounced hook level XNOR `sw_ctrl[3]` as the off-hook bit.
- R6: No write frame ever targets address 4, 6 or 7. Each trigger produces exactly five write frames.
- R7: While `rd_mode` is high, read frames to address 4 and address 2 alternate. Data bits are sampled from `ser_dout` on the rising edges of the data phase. `led_status` takes the 4 bits read from address 4, and `led_echo` takes bit 1 read from address 2. LEDs change only while `ser_cs_n` is high.
- R8: While `rd_mode` is low, no read frame is started and the LEDs keep their values.
- R9: A trigger that arrives during a write sequence is held. A complete second sequence follows once the first one ends.
- R10: A level change on `btn_write` or `hook_in` that lasts fewer than `DEB_CYCLES` clocks after synchronisation starts nothing.
- R11: Reset sets `ser_cs_n` high, `ser_clk` low, `ser_din` low and both LED outputs low.
- R12: Between frames, `ser_cs_n` stays high for at least `CS_GAP` clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_ctrl | input | 4 | Control switches; bit 3 is the off-hook / hook-polarity switch |
| sw_lsp_a | input | 4 | Switches for address 1 |
| sw_lsp_b | input | 4 | Switches for address 2 (bit 1 not written) |
| sw_thr | input | 4 | Switches for address 3 |
| sw_div | input | 3 | Switches for address 5, bits 2..0 |
| btn_write | input | 1 | Momentary write button, active high |
| hook_in | input | 1 | External hook-command level |
| rd_mode | input | 1 | High enables status polling |
| ser_dout | input | 1 | Serial data from the chip |
| ser_cs_n | output | 1 | Chip select, active low |
| ser_clk | output | 1 | Serial clock |
| ser_din | output | 1 | Serial data to the chip |
| led_status | output | 4 | Last value read from address 4 |
| led_echo | output | 1 | Last echo bit read from address 2 |

## Verification
The assertions only look at the serial pins and the LED outputs. They assume the clock and reset are clean, and they place no limits on how the switches, button or hook input are driven. The bench holds switch values steady from just before a trigger until that sequence's last frame has gone out, because frames are built from the live switches. It also keeps every intended button or hook change well beyond the debounce length, except in the deliberate short-glitch cases. The serial peripheral model in the bench changes `ser_dout` only on rising `ser_clk` edges. The design's sample is therefore always taken one full serial period after the data is presented.

// File: rtl/swcfg_pkg.sv
package swcfg_pkg;

    localparam int ADDR_W  = 3;
    localparam int DATA_W  = 4;
    localparam int FRAME_W = 1 + ADDR_W + DATA_W;
    localparam int NUM_WR  = 5;
    localparam int ECHO_BIT = 1;
    localparam int HOOK_BIT = 3;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] nib_t;

    typedef struct packed {
        logic  rd;
        addr_t addr;
        nib_t  data;
    } frame_t;

    typedef struct packed {
        nib_t       ctrl;
        nib_t       lsp_a;
        nib_t       lsp_b;
        nib_t       thr;
        logic [2:0] div;
    } sw_image_t;

    typedef enum logic [1:0] {SQ_IDLE, SQ_WRITE, SQ_POLL} seq_state_e;
    typedef enum logic [1:0] {SH_IDLE, SH_BITS, SH_GAP} sh_state_e;

    localparam addr_t A_CTRL  = 3'd0;
    localparam addr_t A_LSP_A = 3'd1;
    localparam addr_t A_LSP_B = 3'd2;
    localparam addr_t A_THR   = 3'd3;
    localparam addr_t A_STAT  = 3'd4;
    localparam addr_t A_DIV   = 3'd5;

    // Write frame for slot idx of a sequence (slots map to addresses 0,1,2,3,5)
    function automatic frame_t wr_frame(input logic [2:0] idx, input sw_image_t sw,
                                        input logic hook_bit);
        frame_t f;
        f.rd = 1'b0;
        case (idx)
            3'd0: begin f.addr = A_CTRL;  f.data = {hook_bit, sw.ctrl[2:0]}; end
            3'd1: begin f.addr = A_LSP_A; f.data = sw.lsp_a; end
            3'd2: begin f.addr = A_LSP_B; f.data = sw.lsp_b & ~(nib_t'(1) << ECHO_BIT); end
            3'd3: begin f.addr = A_THR;   f.data = sw.thr; end
            default: begin f.addr = A_DIV; f.data = {1'b0, sw.div}; end
        endcase
        return f;
    endfunction

    function automatic frame_t rd_frame(input addr_t a);
        frame_t f;
        f.rd   = 1'b1;
        f.addr = a;
        f.data = '0;
        return f;
    endfunction

endpackage

// File: rtl/swcfg_edge_filter.sv
module swcfg_edge_filter #(
    parameter int DEB_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic level,
    output logic toggled
);
    localparam int DW = $clog2(DEB_CYCLES + 1);

    logic [1:0]    sync;
    logic [DW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync    <= '0;
            cnt     <= '0;
            level   <= 1'b0;
            toggled <= 1'b0;
        end else begin
            sync    <= {sync[0], raw};
            toggled <= 1'b0;
            if (sync[1] != level) begin
                if (cnt == DW'(DEB_CYCLES - 1)) begin
                    level   <= sync[1];
                    toggled <= 1'b1;
                    cnt     <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else begin
                cnt <= '0;
            end
        end
    end
endmodule

// File: rtl/swcfg_frame_shifter.sv
module swcfg_frame_shifter
    import swcfg_pkg::*;
#(
    parameter int HALF_DIV = 2,
    parameter int CS_GAP   = 4
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  frame_t frame,
    input  logic   ser_dout,
    output logic   busy,
    output logic   ser_cs_n,
    output logic   ser_clk,
    output logic   ser_din,
    output nib_t   rdata
);
    localparam int MAXC  = (HALF_DIV > CS_GAP) ? HALF_DIV : CS_GAP;
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam int BIT_W = $clog2(FRAME_W);

    sh_state_e          st;
    logic [FRAME_W-1:0] sreg;
    logic [BIT_W-1:0]   bitn;
    logic [CNT_W-1:0]   cnt;
    logic               is_rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= SH_IDLE;
            sreg     <= '0;
            bitn     <= '0;
            cnt      <= '0;
            is_rd    <= 1'b0;
            ser_cs_n <= 1'b1;
            ser_clk  <= 1'b0;
            rdata    <= '0;
        end else begin
            case (st)
                SH_IDLE: begin
                    if (start) begin
                        sreg     <= frame;
                        is_rd    <= frame.rd;
                        bitn     <= '0;
                        cnt      <= '0;
                        ser_cs_n <= 1'b0;
                        st       <= SH_BITS;
                    end
                end
                SH_BITS: begin
                    if (cnt == CNT_W'(HALF_DIV - 1)) begin
                        cnt <= '0;
                        if (!ser_clk) begin
                            ser_clk <= 1'b1;
                            if (is_rd && bitn >= BIT_W'(1 + ADDR_W))
                                rdata <= {rdata[DATA_W-2:0], ser_dout};
                        end else begin
                            ser_clk <= 1'b0;
                            if (bitn == BIT_W'(FRAME_W - 1)) begin
                                ser_cs_n <= 1'b1;
                                st       <= SH_GAP;
                            end else begin
                                bitn <= bitn + 1'b1;
                                sreg <= {sreg[FRAME_W-2:0], 1'b0};
                            end
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SH_GAP: begin
                    if (cnt == CNT_W'(CS_GAP - 1)) begin
                        cnt <= '0;
                        st  <= SH_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: st <= SH_IDLE;
            endcase
        end
    end

    assign busy    = (st != SH_IDLE);
    assign ser_din = (st == SH_BITS) & sreg[FRAME_W-1];
endmodule

// File: rtl/swcfg_sequencer.sv
module swcfg_sequencer
    import swcfg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      btn_evt,
    input  logic      hook_evt,
    input  logic      hook_lvl,
    input  logic      rd_mode,
    input  sw_image_t sw,
    input  logic      busy,
    input  nib_t      rdata,
    output logic      start,
    output frame_t    frame,
    output nib_t      led_status,
    output logic      led_echo
);
    seq_state_e st;
    logic [2:0] idx;
    logic       pend_man, pend_auto, ofh_q;
    addr_t      poll_addr;
    logic       ready, ofh_auto;

    assign ready    = !busy && !start;
    assign ofh_auto = ~(hook_lvl ^ sw.ctrl[HOOK_BIT]);

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= SQ_IDLE;
            idx        <= '0;
            pend_man   <= 1'b0;
            pend_auto  <= 1'b0;
            ofh_q      <= 1'b0;
            poll_addr  <= A_STAT;
            start      <= 1'b0;
            frame      <= '0;
            led_status <= '0;
            led_echo   <= 1'b0;
        end else begin
            start <= 1'b0;
            case (st)
                SQ_IDLE: begin
                    if (ready) begin
                        if (pend_auto) begin
                            pend_auto <= 1'b0;
                            ofh_q     <= ofh_auto;
                            idx       <= '0;
                            frame     <= wr_frame(3'd0, sw, ofh_auto);
                            start     <= 1'b1;
                            st        <= SQ_WRITE;
                        end else if (pend_man) begin
                            pend_man <= 1'b0;
                            ofh_q    <= sw.ctrl[HOOK_BIT];
                            idx      <= '0;
                            frame    <= wr_frame(3'd0, sw, sw.ctrl[HOOK_BIT]);
                            start    <= 1'b1;
                            st       <= SQ_WRITE;
                        end else if (rd_mode) begin
                            frame <= rd_frame(poll_addr);
                            start <= 1'b1;
                            st    <= SQ_POLL;
                        end
                    end
                end
                SQ_WRITE: begin
                    if (ready) begin
                        if (idx == 3'(NUM_WR - 1)) begin
                            st <= SQ_IDLE;
                        end else begin
                            idx   <= idx + 1'b1;
                            frame <= wr_frame(idx + 1'b1, sw, ofh_q);
                            start <= 1'b1;
                        end
                    end
                end
                SQ_POLL: begin
                    if (ready) begin
                        if (poll_addr == A_STAT) begin
                            led_status <= rdata;
                            poll_addr  <= A_LSP_B;
                        end else begin
                            led_echo  <= rdata[ECHO_BIT];
                            poll_addr <= A_STAT;
                        end
                        st <= SQ_IDLE;
                    end
                end
                default: st <= SQ_IDLE;
            endcase
            if (btn_evt)  pend_man  <= 1'b1;
            if (hook_evt) pend_auto <= 1'b1;
        end
    end
endmodule

// File: rtl/swcfg_serial_ctl.sv
module swcfg_serial_ctl
    import swcfg_pkg::*;
#(
    parameter int HALF_DIV   = 2,
    parameter int CS_GAP     = 4,
    parameter int DEB_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] sw_ctrl,
    input  logic [3:0] sw_lsp_a,
    input  logic [3:0] sw_lsp_b,
    input  logic [3:0] sw_thr,
    input  logic [2:0] sw_div,
    input  logic       btn_write,
    input  logic       hook_in,
    input  logic       rd_mode,
    input  logic       ser_dout,
    output logic       ser_cs_n,
    output logic       ser_clk,
    output logic       ser_din,
    output logic [3:0] led_status,
    output logic       led_echo
);
    localparam int NUM_IN = 2;  // index 0: button, index 1: hook

    logic [NUM_IN-1:0] raw_in, lvl, tog;
    assign raw_in = {hook_in, btn_write};

    for (genvar g = 0; g < NUM_IN; g++) begin : g_filt
        swcfg_edge_filter #(.DEB_CYCLES(DEB_CYCLES)) u_filt (
            .clk(clk), .rst(rst), .raw(raw_in[g]),
            .level(lvl[g]), .toggled(tog[g])
        );
    end

    logic      btn_evt, hook_evt, start, busy;
    sw_image_t sw;
    frame_t    frame;
    nib_t      rdata;

    assign btn_evt  = tog[0] & lvl[0];
    assign hook_evt = tog[1];
    assign sw       = '{ctrl: sw_ctrl, lsp_a: sw_lsp_a, lsp_b: sw_lsp_b,
                        thr: sw_thr, div: sw_div};

    swcfg_sequencer u_seq (
        .clk(clk), .rst(rst), .btn_evt(btn_evt), .hook_evt(hook_evt),
        .hook_lvl(lvl[1]), .rd_mode(rd_mode), .sw(sw), .busy(busy),
        .rdata(rdata), .start(start), .frame(frame),
        .led_status(led_status), .led_echo(led_echo)
    );

    swcfg_frame_shifter #(.HALF_DIV(HALF_DIV), .CS_GAP(CS_GAP)) u_shift (
        .clk(clk), .rst(rst), .start(start), .frame(frame), .ser_dout(ser_dout),
        .busy(busy), .ser_cs_n(ser_cs_n), .ser_clk(ser_clk), .ser_din(ser_din),
        .rdata(rdata)
    );
endmodule

// File: rtl/swcfg_serial_ctl_chk.sv
module swcfg_serial_ctl_chk #(
    parameter int CS_GAP = 4
) (
    input logic       clk,
    input logic       rst,
    input logic       ser_cs_n,
    input logic       ser_clk,
    input logic       ser_din,
    input logic [3:0] led_status
);
    logic [7:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst)
            hi_cnt <= 8'hFF;
        else if (ser_cs_n)
            hi_cnt <= (hi_cnt == 8'hFF) ? hi_cnt : hi_cnt + 1'b1;
        else
            hi_cnt <= '0;
    end

    AST_CLK_LOW_OUTSIDE_FRAME: assert property (@(posedge clk) disable iff (rst)
        ser_cs_n |-> !ser_clk); // R1
    AST_DIN_HELD_WHILE_CLK_HIGH: assert property (@(posedge clk) disable iff (rst)
        ser_clk |-> $stable(ser_din)); // R1
    AST_CS_GAP_MIN: assert property (@(posedge clk) disable iff (rst)
        $fell(ser_cs_n) |-> hi_cnt >= 8'(CS_GAP)); // R12
    AST_LED_AT_FRAME_END: assert property (@(posedge clk) disable iff (rst)
        !$stable(led_status) |-> ser_cs_n); // R7
endmodule

bind swcfg_serial_ctl swcfg_serial_ctl_chk #(.CS_GAP(CS_GAP)) u_chk (
    .clk(clk), .rst(rst), .ser_cs_n(ser_cs_n), .ser_clk(ser_clk),
    .ser_din(ser_din), .led_status(led_status)
);

// File: tb/swcfg_serial_ctl_tb_top.sv
module swcfg_serial_ctl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CS_GAP     = 4;
    localparam int NVEC       = 6;
    // fields: [21] auto, [20] hook level, [19:16] ctrl, [15:12] lsp_a, [11:8] lsp_b, [7:4] thr, [3:0] div
    localparam logic [21:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 4'b1011, 4'b0110, 4'b1111, 4'b0101, 4'b0110},
        {1'b0, 1'b0, 4'b0100, 4'b1001, 4'b0010, 4'b1010, 4'b0001},
        {1'b1, 1'b1, 4'b1000, 4'b0011, 4'b1010, 4'b1100, 4'b0111},
        {1'b1, 1'b0, 4'b1111, 4'b1111, 4'b0000, 4'b0011, 4'b0010},
        {1'b1, 1'b1, 4'b0001, 4'b0101, 4'b1101, 4'b0110, 4'b0101},
        {1'b0, 1'b1, 4'b1110, 4'b1100, 4'b0111, 4'b1001, 4'b0000}
    };

    logic clk = 0, rst = 1;
    logic [3:0] sw_ctrl = 0, sw_lsp_a = 0, sw_lsp_b = 0, sw_thr = 0;
    logic [2:0] sw_div = 0;
    logic btn_write = 0, hook_in = 0, rd_mode = 0, ser_dout = 0;
    logic ser_cs_n, ser_clk, ser_din, led_echo;
    logic [3:0] led_status;

    int nchk = 0, nfail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    swcfg_serial_ctl dut_i (
        .clk(clk), .rst(rst), .sw_ctrl(sw_ctrl), .sw_lsp_a(sw_lsp_a),
        .sw_lsp_b(sw_lsp_b), .sw_thr(sw_thr), .sw_div(sw_div),
        .btn_write(btn_write), .hook_in(hook_in), .rd_mode(rd_mode),
        .ser_dout(ser_dout), .ser_cs_n(ser_cs_n), .ser_clk(ser_clk),
        .ser_din(ser_din), .led_status(led_status), .led_echo(led_echo)
    );

    // Serial peripheral model
    logic [7:0] log_q [256];
    int nfr = 0, nrise = 0;
    logic [7:0] sh = 0;
    logic [3:0] dbits = 0;
    logic [3:0] st_val = 0;
    logic echo_val = 0;

    always @(posedge ser_clk or posedge ser_cs_n) begin
        if (ser_cs_n) begin
            if (!rst && nrise > 0) begin
                log_q[nfr % 256] = sh;
                nfr = nfr + 1;
            end
            nrise = 0;
        end else begin
            sh = {sh[6:0], ser_din};
            if (nrise == 3) begin
                dbits = (sh[2:0] == 3'd4) ? st_val :
                        (sh[2:0] == 3'd2) ? {2'b00, echo_val, 1'b0} : 4'h0;
                ser_dout <= dbits[3];
            end else if (nrise >= 4 && nrise <= 6) begin
                ser_dout <= dbits[6 - nrise];
            end
            nrise = nrise + 1;
        end
    end

    // Chip-select high time between frames
    int hi = 0, min_hi = 100000;
    always @(negedge clk) begin
        if (rst) hi = 0;
        else if (ser_cs_n) hi = hi + 1;
        else begin
            if (hi != 0 && hi < min_hi) min_hi = hi;
            hi = 0;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_frames(input int target);
        int t = 0;
        while (nfr < target && t < 20000) begin
            @(negedge clk);
            t++;
        end
    endtask

    task automatic press();
        btn_write = 1;
        cycles(40);
        btn_write = 0;
    endtask

    function automatic logic [7:0] exp_wr(input int slot, input logic [21:0] v, input logic ofh);
        case (slot)
            0: return {1'b0, 3'd0, ofh, v[18:16]};
            1: return {1'b0, 3'd1, v[15:12]};
            2: return {1'b0, 3'd2, v[11:8] & 4'b1101};
            3: return {1'b0, 3'd3, v[7:4]};
            default: return {1'b0, 3'd5, 1'b0, v[2:0]};
        endcase
    endfunction

    initial begin
        begin : watchdog
            fork
                begin
                    repeat (150000) @(posedge clk);
                    nchk++;
                    nfail++;
                    $display("FAIL watchdog expired");
                    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
                    $finish;
                end
            join_none
        end

        cycles(5);
        // R11: reset state
        chk("R11 cs_n", ser_cs_n, 1);
        chk("R11 sclk", ser_clk, 0);
        chk("R11 din", ser_din, 0);
        chk("R11 leds", {led_echo, led_status}, 0);
        rst = 0;
        cycles(10);

        // Vector table: R2, R3, R4, R5, R6
        for (int i = 0; i < NVEC; i++) begin
            logic [21:0] v;
            logic ofh;
            int base;
            v = VEC[i];
            sw_ctrl = v[19:16]; sw_lsp_a = v[15:12]; sw_lsp_b = v[11:8];
            sw_thr = v[7:4]; sw_div = v[2:0];
            cycles(2);
            base = nfr;
            if (v[21]) begin
                hook_in = v[20];
                ofh = ~(v[20] ^ v[19]);
            end else begin
                press();
                ofh = v[19];
            end
            wait_frames(base + 5);
            cycles(150);
            chk(v[21] ? "R4 frame count" : "R6 frame count", nfr - base, 5);
            for (int s = 0; s < 5; s++) begin
                logic [7:0] f;
                f = log_q[(base + s) % 256];
                chk(s == 0 ? (v[21] ? "R5 ctrl frame" : "R3 ctrl frame") : "R2 frame",
                    f, exp_wr(s, v, ofh));
                chk("R6 no write to 4/6/7",
                    (f[7] == 0 && f[6:4] != 4 && f[6:4] < 6), 1);
            end
        end

        // R10: short glitches on button and hook are ignored
        begin
            int base;
            base = nfr;
            btn_write = 1; cycles(5); btn_write = 0;
            cycles(20);
            hook_in = ~hook_in; cycles(6); hook_in = ~hook_in;
            cycles(300);
            chk("R10 glitch ignored", nfr - base, 0);
        end

        // R9: hook edge during a manual sequence is held and served after
        begin
            int base;
            logic [21:0] v;
            v = {2'b00, 4'b0010, 4'b1010, 4'b0101, 4'b1110, 4'b0011};
            sw_ctrl = v[19:16]; sw_lsp_a = v[15:12]; sw_lsp_b = v[11:8];
            sw_thr = v[7:4]; sw_div = v[2:0];
            cycles(2);
            base = nfr;
            press();
            wait_frames(base + 2);
            hook_in = ~hook_in;
            wait_frames(base + 10);
            cycles(150);
            chk("R9 ten frames", nfr - base, 10);
            chk("R9 first ctrl frame", log_q[base % 256], exp_wr(0, v, v[19]));
            chk("R9 second ctrl frame", log_q[(base + 5) % 256],
                exp_wr(0, v, ~(hook_in ^ v[19])));
            chk("R9 second div frame", log_q[(base + 9) % 256], exp_wr(4, v, 1'b0));
        end

        // R7: status polling
        begin
            int base;
            st_val = 4'b1010; echo_val = 1;
            base = nfr;
            rd_mode = 1;
            wait_frames(base + 4);
            cycles(30);
            chk("R7 read frame addr4", log_q[base % 256], 8'b1100_0000);
            chk("R7 read frame addr2", log_q[(base + 1) % 256], 8'b1010_0000);
            chk("R7 led_status", led_status, 4'b1010);
            chk("R7 led_echo", led_echo, 1);
            st_val = 4'b0111; echo_val = 0;
            wait_frames(nfr + 3);
            cycles(30);
            chk("R7 led_status update", led_status, 4'b0111);
            chk("R7 led_echo update", led_echo, 0);
        end

        // R8: polling stops and LEDs hold while rd_mode is low
        begin
            int base;
            rd_mode = 0;
            cycles(200);
            base = nfr;
            st_val = 4'b0001; echo_val = 1;
            cycles(400);
            chk("R8 no read frames", nfr - base, 0);
            chk("R8 led_status held", led_status, 4'b0111);
            chk("R8 led_echo held", led_echo, 0);
        end

        // R12 / R1: chip-select high time and frame activity
        chk("R12 min cs high", (min_hi >= CS_GAP), 1);
        chk("R1 idle bus", {ser_cs_n, ser_clk}, 2'b10);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule